// File: doc/BRIEF.md
# GPIO Output-Latch and Direction Register Port

This block is a 32-pin general-purpose I/O port behind a small word-addressed register file on a simple 32-bit read/write bus. It keeps a latch that holds the level each pin drives and a per-pin direction register that enables the output driver. It also samples the raw pin levels through a synchronizer chain so that software can read them.

The output latch can be written whole, or changed bit by bit through three write-only alias words: set, clear and toggle. Each alias takes a write mask, and only the bits whose mask bit is 1 change. Software can therefore change one pin without first reading the latch, and other writers cannot lose an update. The bus accepts one access per cycle. Writes take effect at the clock edge that accepts them. Read data is registered and is valid in the cycle after the read is accepted.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output latch and the direction register are all zeros, so `pin_out` and `pin_oe` are 0 and every pin is an input.
- R2: A write to word offset 0x00 loads the output latch with the write data. The latch drives `pin_out` from the next cycle, whatever the direction bits hold, and a read of 0x00 returns it. Without an accepted write neither `pin_out` nor `pin_oe` changes.
- R3: A write to offset 0x04 sets to 1 every latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 every latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Offset 0x14 is the direction register. A bit of 1 makes that pin an output (`pin_oe` bit 1) and a bit of 0 makes it an input. The register can be read back, and writing it leaves the latch unchanged.
- R7: A read of offset 0x10 returns the synchronized pin levels, and writes to 0x10 change neither the latch nor the direction register.
- R8: Reads of the alias offsets 0x04, 0x08 and 0x0C return zero, and so do reads of unmapped word offsets. An access whose address bits [1:0] are not 00 is ignored: a write changes nothing and a read returns zero.
- R9: Pin levels pass through two flip-flops. Suppose a level is applied before clock edge E1. A read accepted at E1 or at E2 still returns the old level, and a read accepted at E3 returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address of the access |
| bus_wdata | input | 32 | Write data or write mask |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| pin_in | input | 32 | Raw pin input levels |
| pin_out | output | 32 | Output latch value for each pin |
| pin_oe | output | 32 | Output enable for each pin |

## Verification
The latch is first loaded with a mixed pattern. Masks that overlap bits already at 1 and bits already at 0 then show that set, clear and toggle change only the masked bits, and a repeated toggle shows that the inversion is real rather than a forced value. The direction and output registers are loaded with different patterns, which tells a swapped decode or a shared register apart from a correct one. Pin levels are changed at the same time as reads are issued, to measure the synchronizer depth to the exact cycle. Misaligned and unmapped accesses show that decoding looks at every address bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Word index of each register (byte address bits above [1:0])
   localparam int WORD_DOUT = 0;
   localparam int WORD_SET  = 1;
   localparam int WORD_CLR  = 2;
   localparam int WORD_TOG  = 3;
   localparam int WORD_DIN  = 4;
   localparam int WORD_DIR  = 5;

   typedef struct packed {
      logic dout;
      logic set;
      logic clr;
      logic tog;
      logic dir;
   } wr_strobe_t;

   typedef enum logic [2:0] {
      RD_NONE,
      RD_DOUT,
      RD_DIN,
      RD_DIR
   } rd_src_e;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output wr_strobe_t        wr_stb,
   output logic              rd_stb,
   output rd_src_e           rd_src
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic             wr_ok;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_ok   = bus_en && bus_wr && aligned;
   assign rd_stb  = bus_en && !bus_wr;

   always_comb begin
      wr_stb      = '0;
      wr_stb.dout = wr_ok && (idx == IDX_W'(WORD_DOUT));
      wr_stb.set  = wr_ok && (idx == IDX_W'(WORD_SET));
      wr_stb.clr  = wr_ok && (idx == IDX_W'(WORD_CLR));
      wr_stb.tog  = wr_ok && (idx == IDX_W'(WORD_TOG));
      wr_stb.dir  = wr_ok && (idx == IDX_W'(WORD_DIR));
   end

   always_comb begin
      rd_src = RD_NONE;
      if (aligned) begin
         if (idx == IDX_W'(WORD_DOUT))     rd_src = RD_DOUT;
         else if (idx == IDX_W'(WORD_DIN)) rd_src = RD_DIN;
         else if (idx == IDX_W'(WORD_DIR)) rd_src = RD_DIR;
      end
   end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
   import gpio_port_pkg::*;
#(
   parameter int PIN_COUNT = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  wr_strobe_t           wr_stb,
   input  logic [PIN_COUNT-1:0] wdata,
   output logic [PIN_COUNT-1:0] dout_q,
   output logic [PIN_COUNT-1:0] dir_q
);
   logic [PIN_COUNT-1:0] dout_nxt;

   // One bus access per cycle, so at most one strobe is active
   always_comb begin
      dout_nxt = dout_q;
      if (wr_stb.dout)     dout_nxt = wdata;
      else if (wr_stb.set) dout_nxt = dout_q | wdata;
      else if (wr_stb.clr) dout_nxt = dout_q & ~wdata;
      else if (wr_stb.tog) dout_nxt = dout_q ^ wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
      end else begin
         dout_q <= dout_nxt;
         if (wr_stb.dir) dir_q <= wdata;
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int PIN_COUNT   = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);
   if (PIN_COUNT != DATA_W) begin : g_bad_width
      $error("PIN_COUNT must equal DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover six register words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   wr_strobe_t           wr_stb;
   logic                 rd_stb;
   rd_src_e              rd_src;
   logic [PIN_COUNT-1:0] dout_q;
   logic [PIN_COUNT-1:0] dir_q;
   logic [PIN_COUNT-1:0] din_sync;
   logic [DATA_W-1:0]    rd_mux;
   logic [DATA_W-1:0]    rdata_q;

   gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_en  (bus_en),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .rd_src  (rd_src)
   );

   gpio_out_latch #(.PIN_COUNT(PIN_COUNT)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_stb(wr_stb),
      .wdata (bus_wdata),
      .dout_q(dout_q),
      .dir_q (dir_q)
   );

   gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (din_sync)
   );

   always_comb begin
      case (rd_src)
         RD_DOUT: rd_mux = dout_q;
         RD_DIN:  rd_mux = din_sync;
         RD_DIR:  rd_mux = dir_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign pin_out   = dout_q;
   assign pin_oe    = dir_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
   parameter int PIN_COUNT = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_en,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic [PIN_COUNT-1:0] pin_out,
   input logic [PIN_COUNT-1:0] pin_oe
);
   logic is_wr;
   logic is_rd;
   assign is_wr = bus_en && bus_wr;
   assign is_rd = bus_en && !bus_wr;

   // R3
   set_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && bus_addr == ADDR_W'(5'h04)) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

   // R4
   clr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && bus_addr == ADDR_W'(5'h08)) |=>
      ((pin_out & $past(bus_wdata)) == '0));

   // R5
   tog_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && bus_addr == ADDR_W'(5'h0C)) |=>
      (pin_out == ($past(pin_out) ^ $past(bus_wdata))));

   // R6
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && bus_addr == ADDR_W'(5'h14)) |=>
      (pin_oe == $past(bus_wdata) && $stable(pin_out)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wr |=> ($stable(pin_out) && $stable(pin_oe)));

   // R8
   alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && (bus_addr == ADDR_W'(5'h04) || bus_addr == ADDR_W'(5'h08) ||
                 bus_addr == ADDR_W'(5'h0C))) |=> (bus_rdata == '0));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
   .PIN_COUNT(PIN_COUNT),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_en   (bus_en),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe)
);

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port_regs uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_en   (bus_en),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] r;
      check("R1 pin_out after reset", pin_out, 32'h0);
      check("R1 pin_oe after reset", pin_oe, 32'h0);
      bus_read(5'h00, r); check("R1 data out read", r, 32'h0);
      bus_read(5'h14, r); check("R1 direction read", r, 32'h0);
   endtask

   task automatic t_dout();
      logic [31:0] r;
      bus_write(5'h00, 32'hA5A5_0F0F);
      check("R2 pin_out load", pin_out, 32'hA5A5_0F0F);
      bus_read(5'h00, r); check("R2 readback", r, 32'hA5A5_0F0F);
      bus_write(5'h00, 32'h1234_5678);
      check("R2 pin_out reload", pin_out, 32'h1234_5678);
      check("R2 pin_oe untouched", pin_oe, 32'h0);
   endtask

   task automatic t_set();
      logic [31:0] r;
      bus_write(5'h04, 32'h0000_FFFF);
      check("R3 set mask", pin_out, 32'h1234_FFFF);
      bus_read(5'h04, r); check("R8 set alias reads zero", r, 32'h0);
   endtask

   task automatic t_clr();
      logic [31:0] r;
      bus_write(5'h08, 32'hFF00_00F0);
      check("R4 clear mask", pin_out, 32'h0034_FF0F);
      bus_read(5'h08, r); check("R8 clear alias reads zero", r, 32'h0);
   endtask

   task automatic t_tog();
      logic [31:0] r;
      bus_write(5'h0C, 32'h8000_0001);
      check("R5 toggle first", pin_out, 32'h8034_FF0E);
      bus_write(5'h0C, 32'h8000_0001);
      check("R5 toggle second", pin_out, 32'h0034_FF0F);
      bus_read(5'h0C, r); check("R8 toggle alias reads zero", r, 32'h0);
   endtask

   task automatic t_dir();
      logic [31:0] r;
      bus_write(5'h14, 32'hF0F0_0001);
      check("R6 pin_oe", pin_oe, 32'hF0F0_0001);
      check("R6 latch kept", pin_out, 32'h0034_FF0F);
      bus_read(5'h14, r); check("R6 readback", r, 32'hF0F0_0001);
      bus_read(5'h00, r); check("R6 data out unchanged", r, 32'h0034_FF0F);
   endtask

   task automatic t_din();
      logic [31:0] r;
      @(negedge clk); pin_in = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      bus_read(5'h10, r); check("R7 input read", r, 32'hDEAD_BEEF);
      bus_write(5'h10, 32'h0000_0000);
      check("R7 write ignored pin_out", pin_out, 32'h0034_FF0F);
      check("R7 write ignored pin_oe", pin_oe, 32'hF0F0_0001);
      bus_read(5'h10, r); check("R7 input after write", r, 32'hDEAD_BEEF);
   endtask

   task automatic t_sync_latency();
      logic [31:0] r;
      @(negedge clk);
      pin_in = 32'h0BAD_F00D;
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 5'h10;
      @(negedge clk); r = bus_rdata;
      check("R9 read at edge 1", r, 32'hDEAD_BEEF);
      @(negedge clk); r = bus_rdata;
      check("R9 read at edge 2", r, 32'hDEAD_BEEF);
      @(negedge clk); r = bus_rdata;
      check("R9 read at edge 3", r, 32'h0BAD_F00D);
      bus_en = 1'b0;
   endtask

   task automatic t_decode_edges();
      logic [31:0] r;
      bus_write(5'h01, 32'hFFFF_FFFF);
      check("R8 misaligned write ignored", pin_out, 32'h0034_FF0F);
      bus_write(5'h16, 32'h0000_0000);
      check("R8 misaligned dir write ignored", pin_oe, 32'hF0F0_0001);
      bus_read(5'h02, r); check("R8 misaligned read zero", r, 32'h0);
      bus_read(5'h18, r); check("R8 unmapped read zero", r, 32'h0);
      bus_read(5'h1C, r); check("R8 unmapped read zero hi", r, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dout();
      t_set();
      t_clr();
      t_tog();
      t_dir();
      t_din();
      t_sync_latency();
      t_decode_edges();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule